// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Pair with Trigger Thresholds

This block holds the character queues for one serial channel. The receive queue sits between the deserializer and the host. Each entry keeps the 8-bit character and the three error bits that the line logic attached to it. The transmit queue sits between the host and the serializer and keeps plain bytes. Each queue counts how many entries it holds. It compares that count, or for transmit the free space, against its own threshold. The result drives a level interrupt request and a DMA ready line for each direction.

The threshold for each direction comes from one of two sources. A 2-bit preset selector picks one of four levels. A programmable field takes over whenever it is nonzero, and then sets the threshold at four times its value. A common enable switches both queues between queued operation and a single-entry holding register. Two self-clearing strobes each empty one queue. The serial framing, the baud generator, flow control and the register decoder are outside this block. Those neighbours drive the strobes and fields directly.

Each DMA ready line is produced by a small state machine with two states, `RDY_IDLE` and `RDY_ACTIVE`. In the receive machine, the transition IDLE→ACTIVE is taken when the occupancy reaches the threshold. The transition ACTIVE→IDLE is taken when the queue is empty. In the transmit machine, IDLE→ACTIVE is taken when the free space reaches the threshold, and ACTIVE→IDLE when the queue is full. A flush of the direction forces ACTIVE→IDLE in both machines and blocks IDLE→ACTIVE in the same cycle. Because of this hysteresis, a DMA engine that starts a burst runs it until the queue is drained (receive) or filled (transmit).

Top module: `uart_fifo_pair`

## Requirements
- R1: With `fifo_en`=1, each queue accepts up to 64 entries and returns them in arrival order. `rx_count` and `tx_count` report the occupancy in the cycle after each accepted push or pop.
- R2: A receive entry returns on `rx_dout` the character pushed on `rx_din` and on `rx_eout` the 3 error bits pushed on `rx_ein` in the same cycle.
- R3: A push into a full receive queue is discarded and sets the sticky `rx_overrun`. A push into a full transmit queue is ignored and sets the sticky `tx_overflow`. In both cases the stored contents and count are unchanged.
- R4: When the programmable field is 0, the threshold follows the selector. For receive, selector values 0/1/2/3 give 8/16/56/60 entries. For transmit, they give 8/16/32/56 free spaces. A nonzero programmable value N overrides the selector with a threshold of 4×N.
- R5: `rx_irq` is high exactly while the receive occupancy is at or above the receive threshold. `tx_irq` is high exactly while the transmit free space is at or above the transmit threshold.
- R6: After reset both queues are disabled. While `fifo_en`=0, each queue holds at most one entry and both thresholds are 1.
- R7: A one-cycle `rx_clr` empties only the receive queue and clears `rx_overrun`. `tx_clr` does the same for the transmit queue and `tx_overflow`. Any change of `fifo_en` empties both queues.
- R8: `rx_rdy` rises one cycle after the receive occupancy first reaches the threshold. It then stays high, even below the threshold, until the cycle after the queue becomes empty.
- R9: `tx_rdy` rises one cycle after the transmit free space reaches the threshold. It then stays high until the cycle after the queue becomes full.
- R10: A pop from an empty queue is ignored. The count stays 0 and the next pushed entry is the next one returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = queued mode, 0 = single holding register |
| rx_clr | input | 1 | Self-clearing strobe that empties the receive queue |
| tx_clr | input | 1 | Self-clearing strobe that empties the transmit queue |
| rx_sel | input | 2 | Receive preset level selector |
| rx_prog | input | 4 | Receive programmable level, 0 = use preset |
| tx_sel | input | 2 | Transmit preset level selector |
| tx_prog | input | 4 | Transmit programmable level, 0 = use preset |
| rx_push | input | 1 | Write strobe from the deserializer |
| rx_din | input | 8 | Received character |
| rx_ein | input | 3 | Error bits for the received character |
| rx_pop | input | 1 | Host read strobe |
| rx_dout | output | 8 | Oldest received character |
| rx_eout | output | 3 | Error bits of the oldest character |
| rx_count | output | 7 | Receive occupancy |
| tx_push | input | 1 | Host write strobe |
| tx_din | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Read strobe from the serializer |
| tx_dout | output | 8 | Oldest byte to transmit |
| tx_count | output | 7 | Transmit occupancy |
| rx_irq | output | 1 | Receive threshold interrupt request |
| tx_irq | output | 1 | Transmit threshold interrupt request |
| rx_rdy | output | 1 | Receive DMA ready |
| tx_rdy | output | 1 | Transmit DMA ready |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_overflow | output | 1 | Sticky transmit overflow |

## Verification
The properties assume that the neighbours sample the configuration fields as steady levels. They also assume that a change of `fifo_en` is a deliberate mode switch, which empties both queues on that edge. For this reason, the properties on counts, flags and ready states check only cycles in which the checker's copy of the previous mode equals the current mode. The stimulus changes the mode and the selectors only between scenarios, and always follows a change with a flush or with one quiet cycle. Push and pop strobes are applied for one cycle at a time, so every edge has a single expected occupancy.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int unsigned CHAR_W = 8;
    localparam int unsigned ERR_W  = 3;

    // one receive slot: status bits above the character
    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    // DMA ready hysteresis
    typedef enum logic [0:0] {
        RDY_IDLE   = 1'b0,
        RDY_ACTIVE = 1'b1
    } rdy_state_e;

endpackage

// File: rtl/uart_fifo_store.sv
module uart_fifo_store #(
    parameter  int unsigned W     = 8,
    parameter  int unsigned DEPTH = 64,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          drop
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          is_full;
    logic          wr_ok;
    logic          rd_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign is_full = (count >= cap);
    assign wr_ok   = push && !is_full;
    assign rd_ok   = pop && (count != '0);
    assign drop    = push && is_full && !flush;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (rd_ok) rd_ptr <= bump(rd_ptr);
            if (wr_ok && !rd_ok)      count <= count + 1'b1;
            else if (rd_ok && !wr_ok) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok && !flush) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/uart_trig_select.sv
module uart_trig_select #(
    parameter  int unsigned DEPTH = 64,
    parameter  bit          IS_RX = 1'b1,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = AW + 1,
    localparam int unsigned PW    = $clog2(DEPTH / 4)
) (
    input  logic          fifo_en,
    input  logic [1:0]    sel,
    input  logic [PW-1:0] prog,
    output logic [CW-1:0] level
);

    logic [CW-1:0] preset;

    generate
        if (IS_RX) begin : g_rx_table
            always_comb begin
                unique case (sel)
                    2'd0:    preset = CW'(DEPTH / 8);
                    2'd1:    preset = CW'(DEPTH / 4);
                    2'd2:    preset = CW'(DEPTH - 8);
                    default: preset = CW'(DEPTH - 4);
                endcase
            end
        end else begin : g_tx_table
            always_comb begin
                unique case (sel)
                    2'd0:    preset = CW'(DEPTH / 8);
                    2'd1:    preset = CW'(DEPTH / 4);
                    2'd2:    preset = CW'(DEPTH / 2);
                    default: preset = CW'(DEPTH - 8);
                endcase
            end
        end
    endgenerate

    // disabled: single slot, threshold of one
    assign level = !fifo_en        ? CW'(1) :
                   (prog != '0)    ? CW'({prog, 2'b00}) :
                                     preset;

endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
    import uart_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic start,
    input  logic stop,
    output logic rdy
);

    rdy_state_e state_q;
    rdy_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RDY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RDY_IDLE:   if (!flush && start)  state_d = RDY_ACTIVE;
            RDY_ACTIVE: if (flush || stop)    state_d = RDY_IDLE;
        endcase
    end

    always_comb begin
        rdy = (state_q == RDY_ACTIVE);
    end

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter  int unsigned DEPTH = 64,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = AW + 1,
    localparam int unsigned PW    = $clog2(DEPTH / 4),
    localparam int unsigned RXW   = $bits(rx_entry_t)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              rx_clr,
    input  logic              tx_clr,
    input  logic [1:0]        rx_sel,
    input  logic [PW-1:0]     rx_prog,
    input  logic [1:0]        tx_sel,
    input  logic [PW-1:0]     tx_prog,
    input  logic              rx_push,
    input  logic [CHAR_W-1:0] rx_din,
    input  logic [ERR_W-1:0]  rx_ein,
    input  logic              rx_pop,
    output logic [CHAR_W-1:0] rx_dout,
    output logic [ERR_W-1:0]  rx_eout,
    output logic [CW-1:0]     rx_count,
    input  logic              tx_push,
    input  logic [CHAR_W-1:0] tx_din,
    input  logic              tx_pop,
    output logic [CHAR_W-1:0] tx_dout,
    output logic [CW-1:0]     tx_count,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic              rx_rdy,
    output logic              tx_rdy,
    output logic              rx_overrun,
    output logic              tx_overflow
);

    logic          en_q;
    logic          mode_flip;
    logic          rx_flush;
    logic          tx_flush;
    logic [CW-1:0] cap;
    logic [CW-1:0] rx_level;
    logic [CW-1:0] tx_level;
    logic [CW-1:0] tx_space;
    logic          rx_drop;
    logic          tx_drop;
    rx_entry_t     rx_in;
    rx_entry_t     rx_head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en;
    end

    assign mode_flip = fifo_en ^ en_q;
    assign rx_flush  = rx_clr | mode_flip;
    assign tx_flush  = tx_clr | mode_flip;
    assign cap       = fifo_en ? CW'(DEPTH) : CW'(1);

    // ---------------- storage ----------------
    assign rx_in = '{err: rx_ein, data: rx_din};

    uart_fifo_store #(.W(RXW), .DEPTH(DEPTH)) u_rx_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .cap   (cap),
        .push  (rx_push),
        .din   (rx_in),
        .pop   (rx_pop),
        .dout  (rx_head),
        .count (rx_count),
        .drop  (rx_drop)
    );

    assign rx_dout = rx_head.data;
    assign rx_eout = rx_head.err;

    uart_fifo_store #(.W(CHAR_W), .DEPTH(DEPTH)) u_tx_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .cap   (cap),
        .push  (tx_push),
        .din   (tx_din),
        .pop   (tx_pop),
        .dout  (tx_dout),
        .count (tx_count),
        .drop  (tx_drop)
    );

    // ---------------- thresholds ----------------
    uart_trig_select #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_trig (
        .fifo_en (fifo_en),
        .sel     (rx_sel),
        .prog    (rx_prog),
        .level   (rx_level)
    );

    uart_trig_select #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_trig (
        .fifo_en (fifo_en),
        .sel     (tx_sel),
        .prog    (tx_prog),
        .level   (tx_level)
    );

    assign tx_space = (tx_count >= cap) ? '0 : cap - tx_count;
    assign rx_irq   = (rx_count >= rx_level);
    assign tx_irq   = (tx_space >= tx_level);

    // ---------------- DMA ready ----------------
    uart_dma_ready u_rx_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .start (rx_irq),
        .stop  (rx_count == '0),
        .rdy   (rx_rdy)
    );

    uart_dma_ready u_tx_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .start (tx_irq),
        .stop  (tx_count >= cap),
        .rdy   (tx_rdy)
    );

    // ---------------- sticky error flags ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_overrun  <= 1'b0;
            tx_overflow <= 1'b0;
        end else begin
            if (rx_flush)     rx_overrun  <= 1'b0;
            else if (rx_drop) rx_overrun  <= 1'b1;
            if (tx_flush)     tx_overflow <= 1'b0;
            else if (tx_drop) tx_overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
    parameter  int unsigned DEPTH = 64,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          rx_clr,
    input logic          tx_clr,
    input logic          rx_push,
    input logic          rx_pop,
    input logic          tx_push,
    input logic          tx_pop,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          rx_irq,
    input logic          tx_irq,
    input logic          rx_rdy,
    input logic          tx_rdy,
    input logic          rx_overrun,
    input logic          tx_overflow
);

    logic          en_prev;
    logic          steady;
    logic [CW-1:0] room;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_prev <= 1'b0;
        else        en_prev <= fifo_en;
    end

    assign steady = (fifo_en == en_prev);
    assign room   = fifo_en ? CW'(DEPTH) : CW'(1);

    // R1: occupancy never exceeds the array
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

    // R3: push into a full receive queue leaves count and raises overrun
    a_r3_rx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && rx_count == room && rx_push && !rx_pop && !rx_clr)
        |=> (rx_overrun && rx_count == $past(rx_count)));

    // R3: transmit overflow stays until a flush of that side
    a_r3_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && tx_overflow && !tx_clr) |=> tx_overflow);

    // R6: single slot while disabled
    a_r6_disabled_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !en_prev) |-> (rx_count <= CW'(1) && tx_count <= CW'(1)));

    // R8: ready rises after the receive threshold is met
    a_r8_rx_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && !rx_clr && !rx_rdy && rx_irq) |=> rx_rdy);

    // R8: ready falls after the receive queue is empty
    a_r8_rx_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rdy && rx_count == '0) |=> !rx_rdy);

    // R9: ready falls after the transmit queue is full
    a_r9_tx_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && tx_rdy && tx_count == room) |=> !tx_rdy);

    // R9: ready rises after enough transmit space
    a_r9_tx_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && !tx_clr && !tx_rdy && tx_irq) |=> tx_rdy);

    // R10: pop of an empty queue leaves it empty
    a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0 && !rx_push) |=> (rx_count == '0));

endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_fifo_pair_test.sv
module uart_fifo_pair_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       rx_clr = 1'b0;
    logic       tx_clr = 1'b0;
    logic [1:0] rx_sel = 2'd0;
    logic [3:0] rx_prog = 4'd0;
    logic [1:0] tx_sel = 2'd0;
    logic [3:0] tx_prog = 4'd0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_din = 8'd0;
    logic [2:0] rx_ein = 3'd0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_dout;
    logic [2:0] rx_eout;
    logic [6:0] rx_count;
    logic       tx_push = 1'b0;
    logic [7:0] tx_din = 8'd0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_dout;
    logic [6:0] tx_count;
    logic       rx_irq, tx_irq, rx_rdy, tx_rdy, rx_overrun, tx_overflow;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    uart_fifo_pair uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rx_put(input logic [7:0] d, input logic [2:0] e);
        rx_push = 1'b1; rx_din = d; rx_ein = e;
        step();
        rx_push = 1'b0;
    endtask

    task automatic rx_take();
        rx_pop = 1'b1;
        step();
        rx_pop = 1'b0;
    endtask

    task automatic tx_put(input logic [7:0] d);
        tx_push = 1'b1; tx_din = d;
        step();
        tx_push = 1'b0;
    endtask

    task automatic tx_take();
        tx_pop = 1'b1;
        step();
        tx_pop = 1'b0;
    endtask

    task automatic clr_rx();
        rx_clr = 1'b1;
        step();
        rx_clr = 1'b0;
    endtask

    task automatic clr_tx();
        tx_clr = 1'b1;
        step();
        tx_clr = 1'b0;
    endtask

    function automatic int rx_preset(input int s);
        case (s)
            0: return 8;
            1: return 16;
            2: return 56;
            default: return 60;
        endcase
    endfunction

    function automatic int tx_preset(input int s);
        case (s)
            0: return 8;
            1: return 16;
            2: return 32;
            default: return 56;
        endcase
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(rx_count == 0 && tx_count == 0, "R6 counts in reset", rx_count + tx_count, 0);
        chk(!rx_rdy && !tx_rdy, "R8 ready low in reset", rx_rdy + tx_rdy, 0);
        chk(!rx_overrun && !tx_overflow, "R3 flags low in reset", rx_overrun + tx_overflow, 0);
        rst_n = 1'b1;
        step();
        chk(tx_rdy == 1'b1, "R9 tx ready after reset", tx_rdy, 1);
        chk(tx_irq == 1'b1 && rx_irq == 1'b0, "R5 irq after reset", {tx_irq, rx_irq}, 2);
    endtask

    task automatic t_disabled();
        rx_put(8'h5A, 3'd1);
        chk(rx_count == 1, "R6 disabled rx one entry", rx_count, 1);
        chk(rx_irq == 1'b1, "R6 disabled rx threshold one", rx_irq, 1);
        rx_put(8'hA5, 3'd6);
        chk(rx_count == 1 && rx_overrun, "R6 disabled rx second push dropped", rx_count, 1);
        chk(rx_dout == 8'h5A && rx_eout == 3'd1, "R6 disabled rx holds first", rx_dout, 8'h5A);
        tx_put(8'h11);
        chk(tx_count == 1 && !tx_irq, "R6 disabled tx full at one", tx_count, 1);
        tx_put(8'h22);
        chk(tx_count == 1 && tx_overflow, "R6 disabled tx overflow", tx_count, 1);
        chk(tx_dout == 8'h11, "R6 disabled tx holds first", tx_dout, 8'h11);
        clr_rx();
        clr_tx();
        chk(rx_count == 0 && tx_count == 0, "R7 clear in disabled mode", rx_count + tx_count, 0);
        fifo_en = 1'b1;
        rx_put(8'h33, 3'd0);
        chk(rx_count == 0, "R7 mode change flushes rx", rx_count, 0);
        step();
    endtask

    task automatic t_fill();
        for (int i = 0; i < 64; i++) rx_put(8'(i * 3 + 1), 3'(i % 8));
        chk(rx_count == 64, "R1 rx holds 64", rx_count, 64);
        for (int i = 0; i < 64; i++) begin
            chk(rx_dout == 8'(i * 3 + 1), "R1 rx order", rx_dout, (i * 3 + 1) % 256);
            chk(rx_eout == 3'(i % 8), "R2 rx error bits", rx_eout, i % 8);
            rx_take();
        end
        chk(rx_count == 0, "R1 rx drained", rx_count, 0);
        for (int i = 0; i < 64; i++) tx_put(8'(255 - i));
        chk(tx_count == 64, "R1 tx holds 64", tx_count, 64);
        for (int i = 0; i < 64; i++) begin
            chk(tx_dout == 8'(255 - i), "R1 tx order", tx_dout, 255 - i);
            tx_take();
        end
        chk(tx_count == 0, "R1 tx drained", tx_count, 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 64; i++) rx_put(8'(i), 3'd2);
        chk(!rx_overrun, "R3 no overrun at full", rx_overrun, 0);
        rx_put(8'hEE, 3'd7);
        chk(rx_overrun && rx_count == 64, "R3 rx overrun", rx_count, 64);
        chk(rx_dout == 8'd0, "R3 rx head kept", rx_dout, 0);
        clr_rx();
        chk(!rx_overrun && rx_count == 0, "R7 rx clear resets overrun", rx_overrun, 0);
        for (int i = 0; i < 64; i++) tx_put(8'(i + 100));
        tx_put(8'hEE);
        chk(tx_overflow && tx_count == 64, "R3 tx overflow", tx_count, 64);
        for (int i = 0; i < 63; i++) tx_take();
        chk(tx_dout == 8'd163, "R3 tx last stored byte", tx_dout, 163);
        clr_tx();
        chk(!tx_overflow && tx_count == 0, "R7 tx clear resets overflow", tx_overflow, 0);
    endtask

    task automatic t_trig_rx();
        for (int s = 0; s < 5; s++) begin
            int lvl;
            rx_sel  = 2'(s % 4);
            rx_prog = (s == 4) ? 4'd5 : 4'd0;
            lvl     = (s == 4) ? 20 : rx_preset(s);
            clr_rx();
            for (int k = 0; k < lvl - 1; k++) rx_put(8'(k), 3'd0);
            chk(!rx_irq, "R4 rx below threshold", rx_irq, 0);
            rx_put(8'hFF, 3'd0);
            chk(rx_irq, "R5 rx at threshold", rx_irq, 1);
        end
        rx_sel = 2'd0; rx_prog = 4'd0;
        clr_rx();
    endtask

    task automatic t_trig_tx();
        for (int s = 0; s < 5; s++) begin
            int lvl;
            tx_sel  = 2'(s % 4);
            tx_prog = (s == 4) ? 4'd3 : 4'd0;
            lvl     = (s == 4) ? 12 : tx_preset(s);
            clr_tx();
            for (int k = 0; k < 64 - lvl; k++) tx_put(8'(k));
            chk(tx_irq, "R5 tx space at threshold", tx_irq, 1);
            tx_put(8'hFF);
            chk(!tx_irq, "R4 tx space below threshold", tx_irq, 0);
        end
        tx_sel = 2'd0; tx_prog = 4'd0;
        clr_tx();
    endtask

    task automatic t_clear();
        for (int i = 0; i < 5; i++) rx_put(8'(i), 3'd0);
        for (int i = 0; i < 3; i++) tx_put(8'(i));
        clr_rx();
        chk(rx_count == 0 && tx_count == 3, "R7 rx clear only rx", tx_count, 3);
        clr_tx();
        chk(tx_count == 0, "R7 tx clear", tx_count, 0);
    endtask

    task automatic t_dma_rx();
        for (int i = 0; i < 7; i++) rx_put(8'(i), 3'd0);
        step();
        chk(!rx_rdy, "R8 rx ready below threshold", rx_rdy, 0);
        rx_put(8'd7, 3'd0);
        chk(!rx_rdy, "R8 rx ready registered", rx_rdy, 0);
        step();
        chk(rx_rdy, "R8 rx ready rises", rx_rdy, 1);
        for (int i = 0; i < 7; i++) rx_take();
        chk(rx_rdy, "R8 rx ready holds until empty", rx_rdy, 1);
        rx_take();
        step();
        chk(!rx_rdy, "R8 rx ready falls when empty", rx_rdy, 0);
    endtask

    task automatic t_dma_tx();
        step();
        chk(tx_rdy, "R9 tx ready with empty queue", tx_rdy, 1);
        for (int i = 0; i < 63; i++) tx_put(8'(i));
        chk(tx_rdy, "R9 tx ready holds until full", tx_rdy, 1);
        tx_put(8'd63);
        step();
        chk(!tx_rdy, "R9 tx ready falls when full", tx_rdy, 0);
        tx_take();
        step();
        chk(!tx_rdy, "R9 tx ready waits for threshold", tx_rdy, 0);
        for (int i = 0; i < 7; i++) tx_take();
        step();
        chk(tx_rdy, "R9 tx ready rises at threshold", tx_rdy, 1);
        clr_tx();
    endtask

    task automatic t_pop_empty();
        rx_take();
        chk(rx_count == 0, "R10 rx pop on empty", rx_count, 0);
        rx_put(8'h77, 3'd5);
        chk(rx_dout == 8'h77 && rx_eout == 3'd5, "R10 rx next entry", rx_dout, 8'h77);
        rx_take();
        tx_take();
        chk(tx_count == 0, "R10 tx pop on empty", tx_count, 0);
        tx_put(8'h88);
        chk(tx_dout == 8'h88, "R10 tx next entry", tx_dout, 8'h88);
        tx_take();
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_fill();
        t_overflow();
        t_trig_rx();
        t_trig_tx();
        t_clear();
        t_dma_rx();
        t_dma_tx();
        t_pop_empty();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule